// File: doc/BRIEF.md
# Dual-Slope Conversion Sequencer

This block is the digital timing core of a dual-slope integrating converter. A prescaler turns the fast input clock into a count rate. The sequencer then runs a repeating loop of three phases: offset nulling (auto-zero), integration of the input for a fixed time, and integration of the reference back towards zero (de-integrate). For each phase it drives one enable line that the analog switch network decodes. The integrator's only input to the block is a comparator that tells whether the integrator output is above zero.

During de-integrate, a four-decade BCD counter counts the elapsed count periods. The count at which the comparator flips is the reading, and it is latched together with the sign of the input. Auto-zero absorbs whatever part of the de-integrate budget went unused, so every cycle has the same length whatever the input level. A reading that does not finish within the full-scale budget is cut off, and an overrange flag is raised.

Top module: `dslope_sequencer`

## Requirements
- R1: While `rst` is high and after its release, `az_en_o` is 1, `int_en_o`, `deint_en_o`, `deint_pos_o` and `result_valid_o` are 0, and `reading_bcd_o`, `reading_neg_o` and `overrange_o` are 0.
- R2: Exactly one of `az_en_o`, `int_en_o`, `deint_en_o` is high in every cycle. They always hand over in the order auto-zero, integrate, de-integrate, then auto-zero again.
- R3: One count period is 4 input clocks. The integrate phase lasts exactly 1000 counts, which is 4000 clocks.
- R4: The input sign is taken from `cmp_above_i` on the last count of the integrate phase only; a low level means a negative input. `deint_pos_o` is 1 throughout de-integrate when the captured sign is negative, is 0 when it is positive, and is 0 outside de-integrate.
- R5: De-integrate ends on the first count at which `cmp_above_i` equals the captured negative flag. The reading is the number of earlier de-integrate counts, from 0 up to 1999, in BCD: units in bits 3:0, tens in bits 7:4, hundreds in bits 11:8, thousands in bits 15:12. Each digit stays at 9 or below.
- R6: `result_valid_o` pulses for exactly one clock, on the clock where de-integrate ends. Reading, sign and overrange outputs change only at that pulse.
- R7: If no crossing is seen within 2000 counts, de-integrate ends after 2000 counts (8000 clocks) and `overrange_o` goes to 1. Reading and sign then keep their previous values. The next valid crossing clears `overrange_o`.
- R8: Successive integrate phases start exactly 4000 counts (16000 clocks) apart for any reading, including overrange.
- R9: The first auto-zero after reset lasts 1000 counts (4000 clocks). A later auto-zero lasts 1000 counts plus the unused remainder of the 2000-count de-integrate budget.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| cmp_above_i | input | 1 | Integrator comparator, 1 when the integrator output is above zero |
| az_en_o | output | 1 | Auto-zero switch enable |
| int_en_o | output | 1 | Signal integrate switch enable |
| deint_en_o | output | 1 | Reference de-integrate switch enable |
| deint_pos_o | output | 1 | Apply positive reference (input was negative) |
| result_valid_o | output | 1 | One-clock pulse at the end of each de-integrate |
| reading_bcd_o | output | 16 | Latched reading, four BCD digits |
| reading_neg_o | output | 1 | Latched sign, 1 for negative input |
| overrange_o | output | 1 | Last conversion exceeded full scale |

## Verification
The bound checker watches these on every cycle:
- the one-hot phase encoding and its fixed hand-over order;
- the 4000-clock integrate length and the 16000-clock spacing of integrate starts;
- the 8000-clock ceiling on de-integrate;
- the single-clock valid pulse, with the outputs frozen between pulses;
- the reading held through an overrange;
- BCD digit range, and gating and stability of the reference polarity.

Only the bench's scenarios can show the following:
- that the latched number equals the count at which the comparator actually flipped, for zero, mid-scale and 1999 inputs of both signs;
- that a wrong comparator level earlier in integrate is ignored;
- that auto-zero length after reset and after each reading matches the remainder rule.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;

   localparam int BCD_BITS = 4;

   typedef enum logic [2:0] {
      PH_AZ    = 3'b001,
      PH_INT   = 3'b010,
      PH_DEINT = 3'b100
   } phase_e;

endpackage

// File: rtl/dsadc_prescaler.sv
module dsadc_prescaler #(
   parameter int DIV = 4
) (
   input  logic clk,
   input  logic rst,
   output logic tick_o
);
   generate
      if (DIV == 1) begin : g_bypass
         wire unused_pins = ^{clk, rst};
         assign tick_o = 1'b1;
      end else begin : g_count
         localparam int PW = $clog2(DIV);
         localparam logic [PW-1:0] LAST = PW'(DIV - 1);
         logic [PW-1:0] div_q;

         always_ff @(posedge clk) begin
            if (rst)
               div_q <= '0;
            else if (div_q == LAST)
               div_q <= '0;
            else
               div_q <= div_q + 1'b1;
         end

         assign tick_o = (div_q == LAST);
      end
   endgenerate
endmodule

// File: rtl/dsadc_bcd_counter.sv
module dsadc_bcd_counter
   import dsadc_pkg::*;
#(
   parameter int DIGITS = 4
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       clr_i,
   input  logic                       inc_i,
   output logic [BCD_BITS*DIGITS-1:0] count_o
);
   logic [DIGITS:0] carry;
   assign carry[0] = inc_i;

   genvar g;
   generate
      for (g = 0; g < DIGITS; g++) begin : g_decade
         logic [BCD_BITS-1:0] dig_q;
         wire                 at_nine = (dig_q == 4'd9);

         always_ff @(posedge clk) begin
            if (rst || clr_i)
               dig_q <= '0;
            else if (carry[g])
               dig_q <= at_nine ? 4'd0 : dig_q + 4'd1;
         end

         assign carry[g+1]                    = carry[g] && at_nine;
         assign count_o[g*BCD_BITS +: BCD_BITS] = dig_q;
      end
   endgenerate

   wire unused_carry_out = carry[DIGITS];
endmodule

// File: rtl/dsadc_phase_ctrl.sv
module dsadc_phase_ctrl
   import dsadc_pkg::*;
#(
   parameter int INT_COUNTS  = 1000,
   parameter int FULL_SCALE  = 2000,
   parameter int AZ_MIN      = 1000,
   parameter int TW          = 12
) (
   input  logic   clk,
   input  logic   rst,
   input  logic   tick_i,
   input  logic   cmp_above_i,
   output phase_e phase_o,
   output logic   neg_o,
   output logic   cnt_clr_o,
   output logic   cnt_inc_o,
   output logic   done_o,
   output logic   ovr_o
);
   localparam logic [TW-1:0] INT_LAST  = TW'(INT_COUNTS - 1);
   localparam logic [TW-1:0] FULL_LAST = TW'(FULL_SCALE - 1);
   localparam logic [TW-1:0] AZ_LAST   = TW'(AZ_MIN - 1);

   phase_e        phase_q, phase_d;
   logic [TW-1:0] tmr_q, tmr_d;
   logic [TW-1:0] spare_q, spare_d;
   logic          neg_q, neg_d;
   logic          crossed;

   // integrator has returned through zero when comparator reads the sign flag
   assign crossed = (cmp_above_i == neg_q);

   always_comb begin
      phase_d   = phase_q;
      tmr_d     = tmr_q;
      spare_d   = spare_q;
      neg_d     = neg_q;
      cnt_clr_o = 1'b0;
      cnt_inc_o = 1'b0;
      done_o    = 1'b0;
      ovr_o     = 1'b0;
      if (tick_i) begin
         unique case (phase_q)
            PH_AZ: begin
               if (tmr_q == AZ_LAST + spare_q) begin
                  phase_d = PH_INT;
                  tmr_d   = '0;
               end else begin
                  tmr_d = tmr_q + 1'b1;
               end
            end
            PH_INT: begin
               if (tmr_q == INT_LAST) begin
                  phase_d   = PH_DEINT;
                  tmr_d     = '0;
                  neg_d     = ~cmp_above_i;
                  cnt_clr_o = 1'b1;
               end else begin
                  tmr_d = tmr_q + 1'b1;
               end
            end
            PH_DEINT: begin
               if (crossed) begin
                  phase_d = PH_AZ;
                  tmr_d   = '0;
                  spare_d = FULL_LAST - tmr_q;
                  done_o  = 1'b1;
               end else if (tmr_q == FULL_LAST) begin
                  phase_d = PH_AZ;
                  tmr_d   = '0;
                  spare_d = '0;
                  done_o  = 1'b1;
                  ovr_o   = 1'b1;
               end else begin
                  tmr_d     = tmr_q + 1'b1;
                  cnt_inc_o = 1'b1;
               end
            end
            default: begin
               phase_d = PH_AZ;
               tmr_d   = '0;
            end
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         phase_q <= PH_AZ;
         tmr_q   <= '0;
         spare_q <= '0;
         neg_q   <= 1'b0;
      end else begin
         phase_q <= phase_d;
         tmr_q   <= tmr_d;
         spare_q <= spare_d;
         neg_q   <= neg_d;
      end
   end

   assign phase_o = phase_q;
   assign neg_o   = neg_q;
endmodule

// File: rtl/dsadc_result_latch.sv
module dsadc_result_latch #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         done_i,
   input  logic         ovr_i,
   input  logic         neg_i,
   input  logic [W-1:0] count_i,
   output logic [W-1:0] reading_o,
   output logic         neg_o,
   output logic         ovr_o,
   output logic         valid_o
);
   always_ff @(posedge clk) begin
      if (rst) begin
         reading_o <= '0;
         neg_o     <= 1'b0;
         ovr_o     <= 1'b0;
         valid_o   <= 1'b0;
      end else begin
         valid_o <= done_i;
         if (done_i) begin
            ovr_o <= ovr_i;
            if (!ovr_i) begin
               reading_o <= count_i;
               neg_o     <= neg_i;
            end
         end
      end
   end
endmodule

// File: rtl/dslope_sequencer.sv
module dslope_sequencer
   import dsadc_pkg::*;
#(
   parameter int PRESCALE     = 4,
   parameter int INT_COUNTS   = 1000,
   parameter int FULL_SCALE   = 2000,
   parameter int CYCLE_COUNTS = 4000,
   parameter int DIGITS       = 4
) (
   input  logic                       clk,
   input  logic                       rst,
   input  logic                       cmp_above_i,
   output logic                       az_en_o,
   output logic                       int_en_o,
   output logic                       deint_en_o,
   output logic                       deint_pos_o,
   output logic                       result_valid_o,
   output logic [BCD_BITS*DIGITS-1:0] reading_bcd_o,
   output logic                       reading_neg_o,
   output logic                       overrange_o
);
   localparam int AZ_MIN = CYCLE_COUNTS - INT_COUNTS - FULL_SCALE;
   localparam int TW     = $clog2(CYCLE_COUNTS + 1);
   localparam int RW     = BCD_BITS * DIGITS;

   generate
      if (PRESCALE < 1) begin : g_bad_prescale
         $error("dslope_sequencer: PRESCALE must be at least 1");
      end
      if (AZ_MIN < 1) begin : g_bad_cycle
         $error("dslope_sequencer: cycle too short for integrate plus full scale");
      end
      if (10 ** DIGITS <= FULL_SCALE) begin : g_bad_digits
         $error("dslope_sequencer: too few decades for full scale");
      end
   endgenerate

   logic   tick;
   phase_e phase;
   logic   neg, cnt_clr, cnt_inc, done, ovr;
   logic [RW-1:0] count;

   dsadc_prescaler #(.DIV(PRESCALE)) u_presc (
      .clk    (clk),
      .rst    (rst),
      .tick_o (tick)
   );

   dsadc_phase_ctrl #(
      .INT_COUNTS (INT_COUNTS),
      .FULL_SCALE (FULL_SCALE),
      .AZ_MIN     (AZ_MIN),
      .TW         (TW)
   ) u_ctrl (
      .clk         (clk),
      .rst         (rst),
      .tick_i      (tick),
      .cmp_above_i (cmp_above_i),
      .phase_o     (phase),
      .neg_o       (neg),
      .cnt_clr_o   (cnt_clr),
      .cnt_inc_o   (cnt_inc),
      .done_o      (done),
      .ovr_o       (ovr)
   );

   dsadc_bcd_counter #(.DIGITS(DIGITS)) u_count (
      .clk     (clk),
      .rst     (rst),
      .clr_i   (cnt_clr),
      .inc_i   (cnt_inc),
      .count_o (count)
   );

   dsadc_result_latch #(.W(RW)) u_latch (
      .clk       (clk),
      .rst       (rst),
      .done_i    (done),
      .ovr_i     (ovr),
      .neg_i     (neg),
      .count_i   (count),
      .reading_o (reading_bcd_o),
      .neg_o     (reading_neg_o),
      .ovr_o     (overrange_o),
      .valid_o   (result_valid_o)
   );

   assign az_en_o     = (phase == PH_AZ);
   assign int_en_o    = (phase == PH_INT);
   assign deint_en_o  = (phase == PH_DEINT);
   assign deint_pos_o = deint_en_o & neg;
endmodule

// File: rtl/dslope_sequencer_chk.sv
module dslope_sequencer_chk #(
   parameter int PRESCALE     = 4,
   parameter int INT_COUNTS   = 1000,
   parameter int FULL_SCALE   = 2000,
   parameter int CYCLE_COUNTS = 4000,
   parameter int DIGITS       = 4
) (
   input logic              clk,
   input logic              rst,
   input logic              az_en_o,
   input logic              int_en_o,
   input logic              deint_en_o,
   input logic              deint_pos_o,
   input logic              result_valid_o,
   input logic [4*DIGITS-1:0] reading_bcd_o,
   input logic              reading_neg_o,
   input logic              overrange_o
);
   localparam logic [31:0] INT_CLKS   = 32'(INT_COUNTS * PRESCALE);
   localparam logic [31:0] DEINT_CLKS = 32'(FULL_SCALE * PRESCALE);
   localparam logic [31:0] CYC_CLKS   = 32'(CYCLE_COUNTS * PRESCALE);

   logic [31:0] int_clks_q, deint_clks_q, cyc_clks_q;
   logic        int_d_q, seen_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         int_clks_q   <= '0;
         deint_clks_q <= '0;
         cyc_clks_q   <= '0;
         int_d_q      <= 1'b0;
         seen_q       <= 1'b0;
      end else begin
         int_clks_q   <= int_en_o ? int_clks_q + 1 : '0;
         deint_clks_q <= deint_en_o ? deint_clks_q + 1 : '0;
         int_d_q      <= int_en_o;
         if (int_en_o && !int_d_q) begin
            cyc_clks_q <= 32'd1;
            seen_q     <= 1'b1;
         end else begin
            cyc_clks_q <= cyc_clks_q + 1;
         end
      end
   end

   AST_ONE_PHASE: assert property (@(posedge clk) disable iff (rst)
      $countones({az_en_o, int_en_o, deint_en_o}) == 1); // R2
   AST_AZ_TO_INT: assert property (@(posedge clk) disable iff (rst)
      $fell(az_en_o) |-> int_en_o); // R2
   AST_INT_TO_DEINT: assert property (@(posedge clk) disable iff (rst)
      $fell(int_en_o) |-> deint_en_o); // R2
   AST_DEINT_TO_AZ: assert property (@(posedge clk) disable iff (rst)
      $fell(deint_en_o) |-> az_en_o); // R2
   AST_INT_LENGTH: assert property (@(posedge clk) disable iff (rst)
      $fell(int_en_o) |-> int_clks_q == INT_CLKS); // R3
   AST_POS_GATED: assert property (@(posedge clk) disable iff (rst)
      deint_pos_o |-> deint_en_o); // R4
   AST_POS_STEADY: assert property (@(posedge clk) disable iff (rst)
      deint_en_o && $past(deint_en_o) |-> $stable(deint_pos_o)); // R4
   AST_VALID_AT_END: assert property (@(posedge clk) disable iff (rst)
      $fell(deint_en_o) |-> result_valid_o); // R6
   AST_VALID_ONLY_END: assert property (@(posedge clk) disable iff (rst)
      result_valid_o |-> $fell(deint_en_o)); // R6
   AST_VALID_PULSE: assert property (@(posedge clk) disable iff (rst)
      result_valid_o |=> !result_valid_o); // R6
   AST_READING_HOLD: assert property (@(posedge clk) disable iff (rst)
      !result_valid_o |-> $stable(reading_bcd_o) && $stable(reading_neg_o) && $stable(overrange_o)); // R6
   AST_DEINT_CEILING: assert property (@(posedge clk) disable iff (rst)
      deint_en_o |-> deint_clks_q < DEINT_CLKS); // R7
   AST_OVR_KEEPS: assert property (@(posedge clk) disable iff (rst)
      result_valid_o && overrange_o |-> $stable(reading_bcd_o) && $stable(reading_neg_o)); // R7
   AST_CYCLE_LEN: assert property (@(posedge clk) disable iff (rst)
      $rose(int_en_o) && seen_q |-> cyc_clks_q == CYC_CLKS); // R8

   genvar g;
   generate
      for (g = 0; g < DIGITS; g++) begin : g_digit
         AST_BCD_DIGIT: assert property (@(posedge clk) disable iff (rst)
            reading_bcd_o[4*g +: 4] <= 4'd9); // R5
      end
   endgenerate
endmodule

bind dslope_sequencer dslope_sequencer_chk #(
   .PRESCALE     (PRESCALE),
   .INT_COUNTS   (INT_COUNTS),
   .FULL_SCALE   (FULL_SCALE),
   .CYCLE_COUNTS (CYCLE_COUNTS),
   .DIGITS       (DIGITS)
) chk_i (
   .clk            (clk),
   .rst            (rst),
   .az_en_o        (az_en_o),
   .int_en_o       (int_en_o),
   .deint_en_o     (deint_en_o),
   .deint_pos_o    (deint_pos_o),
   .result_valid_o (result_valid_o),
   .reading_bcd_o  (reading_bcd_o),
   .reading_neg_o  (reading_neg_o),
   .overrange_o    (overrange_o)
);

// File: tb/dslope_sequencer_tb_top.sv
module dslope_sequencer_tb_top;
   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        cmp = 1'b0;
   logic        az_en, int_en, deint_en, deint_pos, valid, rneg, ovr;
   logic [15:0] reading;
   int          checks = 0;
   int          errors = 0;

   always #10 clk = ~clk;

   dslope_sequencer dut_i (
      .clk            (clk),
      .rst            (rst),
      .cmp_above_i    (cmp),
      .az_en_o        (az_en),
      .int_en_o       (int_en),
      .deint_en_o     (deint_en),
      .deint_pos_o    (deint_pos),
      .result_valid_o (valid),
      .reading_bcd_o  (reading),
      .reading_neg_o  (rneg),
      .overrange_o    (ovr)
   );

   localparam int NV = 6;
   // deint counts before the comparator flips (-1: never flips), and input sign
   localparam int VN[NV]   = '{0, 1999, 537, 1234, -1, 42};
   localparam bit VNEG[NV] = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0};

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   function automatic logic [15:0] to_bcd(input int n);
      return {4'(n / 1000 % 10), 4'(n / 100 % 10), 4'(n / 10 % 10), 4'(n % 10)};
   endfunction

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      chk(1'b0, "WDOG", "watchdog expired", 0, 1);
      finish_run();
   end

   // R8: integrate starts spaced by one full cycle
   int cyc_clks = 0;
   bit cyc_seen = 1'b0;
   bit int_prev = 1'b0;
   always @(negedge clk) begin
      if (rst) begin
         cyc_clks = 0;
         cyc_seen = 1'b0;
         int_prev = 1'b0;
      end else begin
         cyc_clks++;
         if (int_en && !int_prev) begin
            if (cyc_seen) chk(cyc_clks == 16000, "R8", "clocks between integrate starts", cyc_clks, 16000);
            cyc_seen = 1'b1;
            cyc_clks = 0;
         end
         int_prev = int_en;
      end
   end

   initial begin
      logic [15:0] exp_read = '0;
      bit          exp_neg  = 1'b0;
      int          c;

      repeat (5) @(negedge clk);
      // R1: reset state
      chk(az_en && !int_en && !deint_en, "R1", "phase in reset", {az_en, int_en, deint_en}, 3'b100);
      chk(!deint_pos && !valid, "R1", "pos/valid in reset", {deint_pos, valid}, 0);
      chk(reading == 0 && !rneg && !ovr, "R1", "result in reset", reading, 0);
      rst = 1'b0;

      // R9: first auto-zero length
      c = 0;
      do begin
         @(negedge clk);
         c++;
      end while (!int_en);
      chk(c == 4000, "R9", "first auto-zero clocks", c, 4000);

      for (int i = 0; i < NV; i++) begin
         int d;
         int exp_d;
         while (!int_en) @(negedge clk);
         // R4: wrong level early, correct level only near the end of integrate
         c = 0;
         while (int_en) begin
            if (c == 0)    cmp = VNEG[i];
            if (c == 3990) cmp = !VNEG[i];
            c++;
            @(negedge clk);
         end
         chk(c == 4000, "R3", "integrate clocks", c, 4000);
         chk(deint_en && !az_en, "R2", "integrate hands to de-integrate", deint_en, 1);
         chk(deint_pos == VNEG[i], "R4", "reference polarity", deint_pos, VNEG[i]);

         d = 0;
         while (deint_en) begin
            if (VN[i] >= 0 && d == 4 * VN[i] + 2) cmp = ~cmp;
            d++;
            @(negedge clk);
         end
         exp_d = (VN[i] >= 0) ? 4 * (VN[i] + 1) : 8000;
         chk(d == exp_d, (VN[i] >= 0) ? "R5" : "R7", "de-integrate clocks", d, exp_d);
         chk(az_en && !deint_pos, "R2", "de-integrate hands to auto-zero", az_en, 1);
         chk(valid, "R6", "valid at end of de-integrate", valid, 1);
         if (VN[i] >= 0) begin
            exp_read = to_bcd(VN[i]);
            exp_neg  = VNEG[i];
         end
         chk(reading == exp_read, (VN[i] >= 0) ? "R5" : "R7", "reading", reading, exp_read);
         chk(rneg == exp_neg, (VN[i] >= 0) ? "R4" : "R7", "sign", rneg, exp_neg);
         chk(ovr == (VN[i] < 0), "R7", "overrange flag", ovr, VN[i] < 0);
         @(negedge clk);
         chk(!valid, "R6", "valid lasts one clock", valid, 0);
      end

      // R1: reset in the middle of de-integrate
      while (!deint_en) @(negedge clk);
      repeat (100) @(negedge clk);
      rst = 1'b1;
      repeat (3) @(negedge clk);
      rst = 1'b0;
      @(negedge clk);
      chk(az_en && !int_en && !deint_en && !deint_pos, "R1", "phase after mid-run reset", az_en, 1);
      chk(reading == 0 && !rneg && !ovr && !valid, "R1", "result after mid-run reset", reading, 0);
      finish_run();
   end
endmodule